// File: doc/BRIEF.md
# Wide Counter Coherent Read Snapshot

This block is an event counter twice as wide as the register bus that reads it. By default the counter is 64 bits and the bus is 32 bits. A hardware pulse on `evt_inc` adds one to the counter in each cycle it is high.

Software reads the counter in two bus accesses:

- **Lower word (word index 0).** This read takes a snapshot of the whole counter at the clock edge where the request is seen. The lower half is captured for the response. The upper half is copied into a holding register. The counter is cleared on that same edge, so the read-clear and the snapshot refer to the same instant.
- **Upper word (word index 1).** This read returns the held copy, never the live upper bits. The two halves software gets therefore always belong to one value.

A small access state machine answers every bus access. Its states are:

- `ST_IDLE`: no access was presented in the previous cycle.
- `ST_RESP_LO`: answers a lower-word read with the captured lower half.
- `ST_RESP_HI`: answers an upper-word read with the holding register.
- `ST_RESP_ZERO`: answers a write, or a read of any other address, with zero.

The next state depends only on the request seen in the current cycle, so any state can move to any state:

- read of index 0 → `ST_RESP_LO`
- read of index 1 → `ST_RESP_HI`
- read of another index, or a write → `ST_RESP_ZERO`
- no request → `ST_IDLE`

Top module: `wide_cnt_snapshot`

## Requirements
- R1: After reset the counter, the holding register and the captured lower half are zero, and `bus_ready` and `bus_rdata` are 0.
- R2: Each cycle with `evt_inc` high and no lower-word read adds one to the counter. The counter wraps modulo 2^(2*DATA_W).
- R3: A read with `bus_addr` = 0 returns, in the following cycle, bits [DATA_W-1:0] of the counter value held just before the request edge.
- R4: A read with `bus_addr` = 0 copies bits [2*DATA_W-1:DATA_W] of that same counter value into the holding register.
- R5: A read with `bus_addr` = 1 returns the holding register, one cycle later. Repeated such reads with no lower-word read in between return the same value, and a read before any lower-word read returns 0.
- R6: A lower-word read clears the counter on its request edge. If `evt_inc` is high in that cycle, the counter becomes 1, so no event is lost.
- R7: Writes to any address, and reads of addresses other than 0 and 1, change neither the counter nor the holding register. Their response data is 0.
- R8: `bus_ready` is high exactly in the cycle after each cycle with `bus_rd` or `bus_wr` high, and low otherwise. Back-to-back accesses are each answered.
- R9: When `bus_rd` and `bus_wr` are both high, the access is treated as a read and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word index of the access |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access (data is ignored) |
| bus_rdata | output | DATA_W | Response data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Response strobe, one cycle after the request |
| evt_inc | input | 1 | Hardware increment pulse |

## Verification
The bench aims at four corner cases:

- **Increment on the sampling edge.** A design that dropped this increment would return 0 on the next lower read instead of 1.
- **Carry into the upper half between the two reads.** Run with a narrow bus, so the upper half changes quickly. A design that read the upper half live would return an upper word that does not match the lower word.
- **Upper reads before any lower read, and repeated upper reads.** These must return zero and then a stable held value. A design that reloaded or failed to hold the buffer would show changing values.
- **Full counter wrap, simultaneous read and write, and stray writes.** Mistakes here show up as wrong counts on the next lower read.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RESP_LO   = 2'd1,
        ST_RESP_HI   = 2'd2,
        ST_RESP_ZERO = 2'd3
    } wcs_state_e;

endpackage

// File: rtl/wcs_counter.sv
module wcs_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             sample,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] inc_ext;
    logic [CNT_W-1:0] cnt_nxt;

    assign inc_ext = {{(CNT_W-1){1'b0}}, inc};

    always_comb begin
        if (sample) begin
            cnt_nxt = inc_ext;
        end else begin
            cnt_nxt = cnt + inc_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

    AST_CLEAR_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> cnt == {{(CNT_W-1){1'b0}}, $past(inc)}); // R6

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, $past(inc)}); // R2

endmodule

// File: rtl/wcs_hold.sv
module wcs_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d)); // R4

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R5

endmodule

// File: rtl/wcs_access_fsm.sv
module wcs_access_fsm
    import wcs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] live_lo,
    input  logic [DATA_W-1:0] held_hi,
    output logic              sample,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(1);

    wcs_state_e        state;
    wcs_state_e        state_nxt;
    logic [DATA_W-1:0] lo_q;

    assign sample = bus_rd && (bus_addr == LO_IDX);

    // Next-state decode: driven only by the request of this cycle.
    always_comb begin
        state_nxt = ST_IDLE;
        if (bus_rd) begin
            if (bus_addr == LO_IDX) begin
                state_nxt = ST_RESP_LO;
            end else if (bus_addr == HI_IDX) begin
                state_nxt = ST_RESP_HI;
            end else begin
                state_nxt = ST_RESP_ZERO;
            end
        end else if (bus_wr) begin
            state_nxt = ST_RESP_ZERO;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Lower half captured on the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (sample) begin
            lo_q <= live_lo;
        end
    end

    // Output decode.
    always_comb begin
        bus_ready = 1'b0;
        bus_rdata = '0;
        unique case (state)
            ST_IDLE: begin
                bus_ready = 1'b0;
                bus_rdata = '0;
            end
            ST_RESP_LO: begin
                bus_ready = 1'b1;
                bus_rdata = lo_q;
            end
            ST_RESP_HI: begin
                bus_ready = 1'b1;
                bus_rdata = held_hi;
            end
            ST_RESP_ZERO: begin
                bus_ready = 1'b1;
                bus_rdata = '0;
            end
            default: begin
                bus_ready = 1'b0;
                bus_rdata = '0;
            end
        endcase
    end

    AST_READY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ready); // R8

    AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |=> !bus_ready); // R8

    AST_WRITE_RETURNS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd) |=> bus_rdata == '0); // R7

    AST_LO_MATCHES_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> bus_rdata == $past(live_lo)); // R3

endmodule

// File: rtl/wide_cnt_snapshot.sv
module wide_cnt_snapshot #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    input  logic              evt_inc
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] held_hi;
    logic              sample;

    wcs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (evt_inc),
        .sample (sample),
        .cnt    (cnt)
    );

    wcs_hold #(.W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sample),
        .d     (cnt[CNT_W-1:DATA_W]),
        .q     (held_hi)
    );

    wcs_access_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .live_lo   (cnt[DATA_W-1:0]),
        .held_hi   (held_hi),
        .sample    (sample),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata)
    );

    AST_PAIR_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> held_hi == $past(cnt[CNT_W-1:DATA_W])); // R4

endmodule

// File: tb/sim_wide_cnt_snapshot.sv
`timescale 1ns/1ps
module sim_wide_cnt_snapshot;

    localparam int DW = 8;
    localparam int AW = 4;
    localparam int CW = 2 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic          evt_inc = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;

    int checks = 0;
    int fails = 0;

    logic [CW-1:0] m_cnt = '0;
    logic [DW-1:0] m_buf = '0;

    always #10 clk = ~clk;

    wide_cnt_snapshot #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .evt_inc   (evt_inc)
    );

    function automatic logic exp_ready(input logic rd, input logic wr);
        return rd | wr;
    endfunction

    function automatic logic [DW-1:0] exp_data(input logic rd, input logic [AW-1:0] a,
                                               input logic [CW-1:0] c, input logic [DW-1:0] b);
        if (rd && a == 0) return c[DW-1:0];
        if (rd && a == 1) return b;
        return '0;
    endfunction

    task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one access at a negedge, check the response one cycle later.
    task automatic step(input string tag, input logic rd, input logic wr,
                        input logic [AW-1:0] a, input logic inc);
        logic          er;
        logic [DW-1:0] ed;
        bus_rd = rd; bus_wr = wr; bus_addr = a; evt_inc = inc;
        er = exp_ready(rd, wr);
        ed = exp_data(rd, a, m_cnt, m_buf);
        if (rd && a == 0) begin
            m_buf = m_cnt[CW-1:DW];
            m_cnt = {{(CW-1){1'b0}}, inc};
        end else begin
            m_cnt = m_cnt + {{(CW-1){1'b0}}, inc};
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " ready"}, {{DW{1'b0}}, bus_ready}, {{DW{1'b0}}, er});
        if (er) check({tag, " data"}, {1'b0, bus_rdata}, {1'b0, ed});
    endtask

    task automatic idle(input int n, input logic inc);
        for (int i = 0; i < n; i++) step("R2 idle", 1'b0, 1'b0, '0, inc);
    endtask

    initial begin
        #(20.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ready", {{DW{1'b0}}, bus_ready}, '0);
        check("R1 rdata", {1'b0, bus_rdata}, '0);
        rst_n = 1'b1;

        step("R5 hi before lo", 1'b1, 1'b0, 1, 1'b0);
        step("R1 lo after reset", 1'b1, 1'b0, 0, 1'b1);   // R6: inc on sampling edge
        step("R6 count is one", 1'b1, 1'b0, 0, 1'b0);
        idle(5, 1'b1);
        step("R3 lo read", 1'b1, 1'b0, 0, 1'b0);
        idle(300, 1'b1);
        step("R3 lo with carry", 1'b1, 1'b0, 0, 1'b1);
        step("R4 hi held", 1'b1, 1'b0, 1, 1'b1);
        idle(600, 1'b1);
        step("R5 hi repeat", 1'b1, 1'b0, 1, 1'b1);
        step("R7 write lo", 1'b0, 1'b1, 0, 1'b1);
        step("R7 write hi", 1'b0, 1'b1, 1, 1'b0);
        step("R7 unmapped rd", 1'b1, 1'b0, 5, 1'b1);
        step("R3 lo after writes", 1'b1, 1'b0, 0, 1'b0);
        step("R4 hi after writes", 1'b1, 1'b0, 1, 1'b0);
        idle(40, 1'b1);
        step("R9 rd and wr", 1'b1, 1'b1, 0, 1'b0);
        step("R8 back to back", 1'b1, 1'b0, 0, 1'b0);
        idle(65539, 1'b1);
        step("R2 wrap lo", 1'b1, 1'b0, 0, 1'b0);
        step("R2 wrap hi", 1'b1, 1'b0, 1, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            logic [AW-1:0] a;
            op = 4'($urandom_range(0, 15));
            a = (op < 12) ? AW'(op[0]) : AW'($urandom_range(0, 15));
            step("R8 random", op < 6, op >= 10, a, 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 400)), 1'b1);
        end

        bus_rd = 1'b0; bus_wr = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule